// File: doc/BRIEF.md
# DAC Conversion Sequencing Controller

This block sits between a simple APB-style register bus and a 12-bit digital-to-analog converter core. Software programs a control word, a settling time and a 16-bit holding word. A conversion is started in one of two ways. In immediate mode, writing the holding word starts it. In triggered mode, one selected source starts it: a software strike, an external pin, one of four timer pulses or one of two PWM pulses. When a conversion starts, the holding word is aligned and width-reduced, then copied into a read-only 12-bit code register that drives the converter.

After the copy the block stays busy for the programmed number of clock cycles and then raises a completion flag. The interrupt line combines the completion flag and the under-run flag with their enables. In DMA mode a one-cycle request is emitted at each conversion start. An under-run is flagged when a conversion loads a holding word that has not been rewritten since the previous load. The output-buffer bypass bit and the channel-grouping bit are only passed through to the analog side.

Top module: `dacseq_ctrl`

## Requirements
- R1: After reset, all registers read 0, and `dac_code`, `irq`, `dma_req`, `buf_bypass` and `group_en` are 0.
- R2: The register offsets are 0x00 control, 0x04 strike, 0x08 holding, 0x0C code (read-only), 0x10 status and 0x14 settle time. The control register keeps only bits 0-8, 10 and 12-16, so writing all ones reads back 0x1F5FF. The settle-time register keeps bits [9:0]. A write to 0x0C changes nothing. Offset 0x04 always reads 0.
- R3: When control bit 0 (enable) is 1 and control bit 4 (trigger mode) is 0, a holding write starts a conversion. The new code appears on `dac_code` one clock after the write's access cycle.
- R4: The code is formed from the holding word (H) as follows. Control bit 10 selects left alignment, and control bits [15:14] = 01 select 8-bit width (any other value selects 12-bit width).
  - 12-bit, right-aligned: H[11:0].
  - 12-bit, left-aligned: H[15:4].
  - 8-bit, right-aligned: {H[7:0], 4'b0}.
  - 8-bit, left-aligned: {H[15:8], 4'b0}.
- R5: A conversion keeps status bit 8 (busy) high for max(S,1) cycles, where S is the settle-time value. Status bit 0 (finish) then sets, and stays clear while busy.
- R6: Writing 1 to status bit 0 clears finish, and a new conversion start also clears it.
- R7: In trigger mode, control bits [7:5] pick the one source that can start a conversion:
  - 000: software strike (write 1 to 0x04 bit 0).
  - 001: external pin.
  - 010 to 101: timers 0 to 3.
  - 110: PWM 0.
  - 111: PWM 1.
  Pulses on sources that are not selected have no effect.
- R8: Control bits [13:12] set how the synchronized pin fires. The edge modes fire once per edge, and the level modes fire on every idle cycle while the level holds.
  - 00: low level.
  - 01: high level.
  - 10: falling edge.
  - 11: rising edge.
- R9: A trigger or holding write that arrives while busy does not start a conversion and is not queued.
- R10: `irq` = (finish AND control bit 1) OR (under-run AND control bit 3).
- R11: With control bit 2 (DMA mode) set, `dma_req` pulses for exactly one cycle, in the cycle the new code appears, and it never pulses with DMA mode clear. In trigger mode, a start whose holding word was not rewritten since the previous load sets status bit 1 (under-run). Writing 1 to status bit 1 clears it.
- R12: `buf_bypass` follows control bit 8, and `group_en` follows control bit 16.
- R13: With control bit 0 clear, no conversion starts, and a holding write made then does not start one when the block is enabled later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 5 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_trig_pin | input | 1 | Asynchronous external trigger pin |
| timer_trig | input | 4 | One-cycle timer pulses, bit i is timer i |
| pwm_trig | input | 2 | One-cycle PWM pulses, bit i is PWM unit i |
| dac_code | output | 12 | Code driving the converter core |
| buf_bypass | output | 1 | Output buffer bypass control |
| group_en | output | 1 | Two-channel grouping control |
| dma_req | output | 1 | One-cycle DMA request at conversion start |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the busy window cycle by cycle through the interrupt line, including a settle value of zero. A design that counted one cycle too many or too few, or that stalled forever on zero, would miss the expected cycle. It strikes a trigger during a long busy window and then waits well past it. A design that queued the trigger would later show the rewritten code, and one that did not block it would show it at once. It covers all four alignment and width combinations with one asymmetric holding word, so a swapped slice or a missing zero fill shows up as a wrong code. It drives each pin-sensing mode with levels that should and should not fire, and it checks that a second load of a stale holding word raises the under-run flag while a fresh load does not.

// File: rtl/dacseq_pkg.sv
`timescale 1ns/1ps
// dacseq_pkg: register offsets, control field positions and the
// pin-sensing encoding shared by the conversion controller modules.
package dacseq_pkg;
    localparam int OFF_CTL   = 'h00;
    localparam int OFF_STRIKE = 'h04;
    localparam int OFF_HOLD  = 'h08;
    localparam int OFF_CODE  = 'h0C;
    localparam int OFF_STS   = 'h10;
    localparam int OFF_TIME  = 'h14;

    localparam int BIT_EN     = 0;
    localparam int BIT_IEN    = 1;
    localparam int BIT_DMA    = 2;
    localparam int BIT_UIEN   = 3;
    localparam int BIT_TRGM   = 4;
    localparam int BIT_SEL_LO = 5;
    localparam int BIT_BYP    = 8;
    localparam int BIT_LEFT   = 10;
    localparam int BIT_SNS_LO = 12;
    localparam int BIT_WID_LO = 14;
    localparam int BIT_GRP    = 16;

    localparam logic [31:0] CTL_KEEP = 32'h0001_F5FF;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } pin_sense_e;
endpackage

// File: rtl/dacseq_align.sv
`timescale 1ns/1ps
// dacseq_align: forms the converter code from the holding word.
// Assumes HOLD_W >= DATA_W >= NARROW_W. Narrow samples are placed in
// the top NARROW_W code bits with the remaining low bits zero.
module dacseq_align #(
    parameter int HOLD_W   = 16,
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8
) (
    input  logic [HOLD_W-1:0] hold,
    input  logic              left,
    input  logic              narrow,
    output logic [DATA_W-1:0] code
);
    localparam int PAD_W = DATA_W - NARROW_W;

    // Select the slice by alignment and width.
    always_comb begin
        if (narrow) begin
            if (left) code = {hold[HOLD_W-1 -: NARROW_W], {PAD_W{1'b0}}};
            else      code = {hold[NARROW_W-1:0], {PAD_W{1'b0}}};
        end else begin
            if (left) code = hold[HOLD_W-1 -: DATA_W];
            else      code = hold[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/dacseq_trig.sv
`timescale 1ns/1ps
// dacseq_trig: selects one conversion trigger source. The external pin
// is assumed asynchronous and passes a SYNC_N flop synchronizer before
// edge or level sensing; all other sources are assumed to be one-cycle
// pulses already in this clock domain.
module dacseq_trig
    import dacseq_pkg::*;
#(
    parameter int NTMR   = 4,
    parameter int NPWM   = 2,
    parameter int SYNC_N = 2,
    localparam int NSRC  = 2 + NTMR + NPWM,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_pulse,
    input  logic             ext_pin,
    input  logic [NTMR-1:0]  tmr_pulse,
    input  logic [NPWM-1:0]  pwm_pulse,
    input  logic [SEL_W-1:0] sel,
    input  pin_sense_e       sense,
    output logic             fire
);
    logic [SYNC_N-1:0] sync_q;
    logic              pin_d;
    logic              pin_s;
    logic              pin_cond;
    logic [NSRC-1:0]   src;

    assign pin_s = sync_q[SYNC_N-1];

    // Synchronize the pin and keep its previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            pin_d  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], ext_pin};
            pin_d  <= pin_s;
        end
    end

    // Apply the programmed pin-sensing mode.
    always_comb begin
        unique case (sense)
            SENSE_LOW:  pin_cond = ~pin_s;
            SENSE_HIGH: pin_cond = pin_s;
            SENSE_FALL: pin_cond = pin_d & ~pin_s;
            SENSE_RISE: pin_cond = ~pin_d & pin_s;
            default:    pin_cond = 1'b0;
        endcase
    end

    assign src  = {pwm_pulse, tmr_pulse, pin_cond, sw_pulse};
    assign fire = src[sel];

    // R8
    edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_RISE && pin_cond) |=> !pin_cond);
endmodule

// File: rtl/dacseq_settle.sv
`timescale 1ns/1ps
// dacseq_settle: holds busy for max(settle,1) cycles after a start and
// then raises finish. Assumes start only arrives while not busy.
module dacseq_settle #(
    parameter int SETTLE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle,
    input  logic                clr_finish,
    output logic                busy,
    output logic                finish
);
    logic [SETTLE_W-1:0] cnt_q;

    // Count the settling window and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            finish <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            finish <= 1'b0;
            cnt_q  <= SETTLE_W'(1);
        end else if (busy) begin
            if (cnt_q >= settle) begin
                busy   <= 1'b0;
                finish <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (clr_finish) begin
            finish <= 1'b0;
        end
    end

    // R5
    finish_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> finish);
    // R6
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !finish));
endmodule

// File: rtl/dacseq_ctrl.sv
`timescale 1ns/1ps
// dacseq_ctrl: register front end and conversion sequencing for a
// 12-bit converter core. Bus transfers follow the two-phase APB-style
// handshake with zero wait states; reads are combinational.
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int HOLD_W   = 16,
    parameter int DATA_W   = 12,
    parameter int NARROW_W = 8,
    parameter int SETTLE_W = 10,
    parameter int NTMR     = 4,
    parameter int NPWM     = 2,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              ext_trig_pin,
    input  logic [NTMR-1:0]   timer_trig,
    input  logic [NPWM-1:0]   pwm_trig,
    output logic [DATA_W-1:0] dac_code,
    output logic              buf_bypass,
    output logic              group_en,
    output logic              dma_req,
    output logic              irq
);
    localparam int SEL_W = $clog2(2 + NTMR + NPWM);

    logic [31:0]         ctl_q;
    logic [HOLD_W-1:0]   hold_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [DATA_W-1:0]   dout_q;
    logic                udr_q, fresh_q, strike_q, hold_wr_q, dma_req_q;
    logic                wr_en, wr_ctl, wr_strike, wr_hold, wr_sts, wr_time;
    logic                trig_fire, conv_busy, conv_finish, conv_start;
    logic [DATA_W-1:0]   aligned;

    assign wr_en     = psel & penable & pwrite;
    assign wr_ctl    = wr_en && (paddr == ADDR_W'(OFF_CTL));
    assign wr_strike = wr_en && (paddr == ADDR_W'(OFF_STRIKE));
    assign wr_hold   = wr_en && (paddr == ADDR_W'(OFF_HOLD));
    assign wr_sts    = wr_en && (paddr == ADDR_W'(OFF_STS));
    assign wr_time   = wr_en && (paddr == ADDR_W'(OFF_TIME));

    // Store the programmable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            hold_q   <= '0;
            settle_q <= '0;
        end else begin
            if (wr_ctl)  ctl_q    <= pwdata & CTL_KEEP;
            if (wr_hold) hold_q   <= pwdata[HOLD_W-1:0];
            if (wr_time) settle_q <= pwdata[SETTLE_W-1:0];
        end
    end

    // Produce the one-cycle software strike and the holding-write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strike_q  <= 1'b0;
            hold_wr_q <= 1'b0;
        end else begin
            strike_q  <= wr_strike & pwdata[0];
            hold_wr_q <= wr_hold;
        end
    end

    dacseq_trig #(
        .NTMR(NTMR), .NPWM(NPWM), .SYNC_N(SYNC_N)
    ) u_trig (
        .clk(clk), .rst_n(rst_n),
        .sw_pulse(strike_q), .ext_pin(ext_trig_pin),
        .tmr_pulse(timer_trig), .pwm_pulse(pwm_trig),
        .sel(ctl_q[BIT_SEL_LO +: SEL_W]),
        .sense(pin_sense_e'(ctl_q[BIT_SNS_LO +: 2])),
        .fire(trig_fire)
    );

    assign conv_start = ctl_q[BIT_EN] & ~conv_busy &
                        (ctl_q[BIT_TRGM] ? trig_fire : hold_wr_q);

    dacseq_align #(
        .HOLD_W(HOLD_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)
    ) u_align (
        .hold(hold_q), .left(ctl_q[BIT_LEFT]),
        .narrow(ctl_q[BIT_WID_LO +: 2] == 2'b01),
        .code(aligned)
    );

    dacseq_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .settle(settle_q),
        .clr_finish(wr_sts & pwdata[0]),
        .busy(conv_busy), .finish(conv_finish)
    );

    // Load the code, track holding freshness, under-run and DMA request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            fresh_q   <= 1'b0;
            udr_q     <= 1'b0;
            dma_req_q <= 1'b0;
        end else begin
            dma_req_q <= conv_start & ctl_q[BIT_DMA];
            if (conv_start) dout_q <= aligned;
            if (wr_hold)         fresh_q <= 1'b1;
            else if (conv_start) fresh_q <= 1'b0;
            if (conv_start && ctl_q[BIT_TRGM] && !fresh_q) udr_q <= 1'b1;
            else if (wr_sts && pwdata[1])                  udr_q <= 1'b0;
        end
    end

    // Return the addressed register on reads.
    always_comb begin
        prdata = '0;
        case (paddr)
            ADDR_W'(OFF_CTL):  prdata = ctl_q;
            ADDR_W'(OFF_HOLD): prdata = 32'(hold_q);
            ADDR_W'(OFF_CODE): prdata = 32'(dout_q);
            ADDR_W'(OFF_STS):  prdata = 32'({conv_busy, 6'b0, udr_q, conv_finish});
            ADDR_W'(OFF_TIME): prdata = 32'(settle_q);
            default:           prdata = '0;
        endcase
    end

    assign dac_code   = dout_q;
    assign dma_req    = dma_req_q;
    assign buf_bypass = ctl_q[BIT_BYP];
    assign group_en   = ctl_q[BIT_GRP];
    assign irq        = (conv_finish & ctl_q[BIT_IEN]) | (udr_q & ctl_q[BIT_UIEN]);

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(dout_q));
    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> $stable(dout_q));
    // R11
    dma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ctl_q[BIT_DMA]) |=> dma_req_q);
    // R11
    dma_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_q |=> !dma_req_q);
endmodule

// File: tb/dacseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dacseq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        ext_trig_pin = 1'b0;
    logic [3:0]  timer_trig = '0;
    logic [1:0]  pwm_trig = '0;
    logic [11:0] dac_code;
    logic        buf_bypass, group_en, dma_req, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dacseq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ext_trig_pin(ext_trig_pin), .timer_trig(timer_trig),
        .pwm_trig(pwm_trig), .dac_code(dac_code), .buf_bypass(buf_bypass),
        .group_en(group_en), .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_tmr(input int i);
        timer_trig[i] = 1'b1;
        @(negedge clk);
        timer_trig = '0;
    endtask

    task automatic pulse_pwm(input int i);
        pwm_trig[i] = 1'b1;
        @(negedge clk);
        pwm_trig = '0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1 dac_code", 32'(dac_code), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 bypass/group", 32'({buf_bypass, group_en}), 0);
        bus_rd(5'h00, r); chk("R1 ctl", r, 0);
        bus_rd(5'h10, r); chk("R1 status", r, 0);
    endtask

    task automatic t_regs();
        logic [31:0] r;
        bus_wr(5'h00, 32'hFFFF_FFFF);
        bus_rd(5'h00, r); chk("R2 ctl readback", r, 32'h0001_F5FF);
        chk("R12 bypass", 32'(buf_bypass), 1);
        chk("R12 group", 32'(group_en), 1);
        bus_wr(5'h00, 32'h0);
        chk("R12 cleared", 32'({buf_bypass, group_en}), 0);
        bus_wr(5'h14, 32'h0000_FFFF);
        bus_rd(5'h14, r); chk("R2 settle readback", r, 32'h3FF);
        bus_wr(5'h0C, 32'h0000_0FFF);
        bus_rd(5'h0C, r); chk("R2 code not writable", r, 0);
        chk("R2 dac_code unchanged", 32'(dac_code), 0);
        bus_wr(5'h04, 32'h1);
        bus_rd(5'h04, r); chk("R2 strike reads 0", r, 0);
        bus_wr(5'h14, 32'd2);
    endtask

    task automatic t_align();
        bus_wr(5'h00, 32'h1);
        bus_wr(5'h08, 32'hABCD);
        @(negedge clk);
        chk("R3 code one cycle after write", 32'(dac_code), 32'hBCD);
        ticks(5);
        bus_wr(5'h00, 32'h401);
        bus_wr(5'h08, 32'hABCD); ticks(5);
        chk("R4 12-bit left", 32'(dac_code), 32'hABC);
        bus_wr(5'h00, 32'h4001);
        bus_wr(5'h08, 32'hABCD); ticks(5);
        chk("R4 8-bit right", 32'(dac_code), 32'hCD0);
        bus_wr(5'h00, 32'h4401);
        bus_wr(5'h08, 32'hABCD); ticks(5);
        chk("R4 8-bit left", 32'(dac_code), 32'hAB0);
    endtask

    task automatic t_disabled();
        bus_wr(5'h00, 32'h0);
        bus_wr(5'h08, 32'h0123); ticks(5);
        chk("R13 disabled no start", 32'(dac_code), 32'hAB0);
        bus_wr(5'h00, 32'h1); ticks(5);
        chk("R13 no late start", 32'(dac_code), 32'hAB0);
    endtask

    task automatic measure(input int s, input int exp_k);
        int k;
        bus_wr(5'h14, 32'(s));
        bus_wr(5'h08, 32'h0456);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq && k < 2000);
        chk($sformatf("R5 finish cycle settle=%0d", s), 32'(k), 32'(exp_k));
    endtask

    task automatic t_settle();
        logic [31:0] r;
        bus_wr(5'h00, 32'h3);
        measure(5, 6);
        measure(0, 2);
        bus_wr(5'h14, 32'd40);
        bus_wr(5'h08, 32'h0457);
        bus_rd(5'h10, r); chk("R5 busy during settle", r, 32'h100);
        ticks(50);
        bus_rd(5'h10, r); chk("R6 finish set after settle", r, 32'h001);
    endtask

    task automatic t_finish_clr();
        logic [31:0] r;
        bus_wr(5'h14, 32'd2);
        chk("R10 irq on finish", 32'(irq), 1);
        bus_wr(5'h10, 32'h1);
        chk("R6 W1C clears irq", 32'(irq), 0);
        bus_rd(5'h10, r); chk("R6 W1C status", r, 0);
        bus_wr(5'h08, 32'h0458); ticks(5);
        chk("R10 irq again", 32'(irq), 1);
        bus_wr(5'h00, 32'h1);
        chk("R10 irq masked", 32'(irq), 0);
    endtask

    task automatic t_trig_sel();
        bus_wr(5'h00, 32'h91);          // trigger mode, timer 2 (100)
        bus_wr(5'h08, 32'h0111); ticks(4);
        chk("R7 write in trigger mode no start", 32'(dac_code), 32'h458);
        pulse_tmr(0); pulse_pwm(1); ticks(4);
        chk("R7 unselected ignored", 32'(dac_code), 32'h458);
        pulse_tmr(2); ticks(4);
        chk("R7 timer2 fires", 32'(dac_code), 32'h111);
        bus_wr(5'h00, 32'h11);          // software strike (000)
        bus_wr(5'h08, 32'h0222);
        bus_wr(5'h04, 32'h1); ticks(4);
        chk("R7 software strike", 32'(dac_code), 32'h222);
        bus_wr(5'h00, 32'hF1);          // PWM 1 (111)
        bus_wr(5'h08, 32'h0333);
        pulse_pwm(1); ticks(4);
        chk("R7 pwm1 fires", 32'(dac_code), 32'h333);
    endtask

    task automatic t_ext();
        bus_wr(5'h00, 32'h3031);        // pin, rising
        bus_wr(5'h08, 32'h0444);
        ext_trig_pin = 1'b1; ticks(6);
        chk("R8 rising edge", 32'(dac_code), 32'h444);
        bus_wr(5'h08, 32'h0555); ticks(10);
        chk("R8 steady high no edge", 32'(dac_code), 32'h444);
        bus_wr(5'h00, 32'h2031);        // falling
        ticks(4);
        chk("R8 falling idle", 32'(dac_code), 32'h444);
        ext_trig_pin = 1'b0; ticks(6);
        chk("R8 falling edge", 32'(dac_code), 32'h555);
        bus_wr(5'h00, 32'h1031);        // high level
        bus_wr(5'h08, 32'h0666); ticks(6);
        chk("R8 high level absent", 32'(dac_code), 32'h555);
        ext_trig_pin = 1'b1; ticks(6);
        chk("R8 high level", 32'(dac_code), 32'h666);
        bus_wr(5'h00, 32'h0031);        // low level
        bus_wr(5'h08, 32'h0777); ticks(6);
        chk("R8 low level absent", 32'(dac_code), 32'h666);
        ext_trig_pin = 1'b0; ticks(6);
        chk("R8 low level", 32'(dac_code), 32'h777);
        ext_trig_pin = 1'b1; ticks(6);
        bus_wr(5'h00, 32'h1);
    endtask

    task automatic t_busy();
        logic [31:0] r;
        bus_wr(5'h14, 32'd100);
        bus_wr(5'h00, 32'h51);          // trigger mode, timer 0 (010)
        bus_wr(5'h10, 32'h3);
        bus_wr(5'h08, 32'h0888);
        pulse_tmr(0); ticks(3);
        chk("R9 first load", 32'(dac_code), 32'h888);
        bus_wr(5'h08, 32'h0999);
        pulse_tmr(0); ticks(3);
        chk("R9 trigger while busy ignored", 32'(dac_code), 32'h888);
        ticks(150);
        chk("R9 not queued", 32'(dac_code), 32'h888);
        bus_rd(5'h10, r); chk("R9 status after", r, 32'h001);
        pulse_tmr(0); ticks(3);
        chk("R9 idle trigger loads fresh", 32'(dac_code), 32'h999);
        ticks(110);
        bus_wr(5'h14, 32'd2);
    endtask

    task automatic t_dma();
        logic [31:0] r;
        bus_wr(5'h00, 32'h55);          // DMA, trigger mode, timer 0
        bus_wr(5'h10, 32'h3);
        bus_wr(5'h08, 32'h0AAA);
        pulse_tmr(0);
        chk("R11 dma_req pulse", 32'(dma_req), 1);
        @(negedge clk);
        chk("R11 dma_req one cycle", 32'(dma_req), 0);
        chk("R11 code with dma", 32'(dac_code), 32'hAAA);
        ticks(5);
        bus_rd(5'h10, r); chk("R11 no under-run when fresh", r & 32'h2, 0);
        pulse_tmr(0); ticks(5);
        bus_rd(5'h10, r); chk("R11 under-run on stale", r & 32'h2, 32'h2);
        bus_wr(5'h00, 32'h5D);
        chk("R10 irq on under-run", 32'(irq), 1);
        bus_wr(5'h10, 32'h2);
        chk("R10 irq after under-run clear", 32'(irq), 0);
        bus_rd(5'h10, r); chk("R11 under-run W1C", r & 32'h2, 0);
        bus_wr(5'h00, 32'h51);
        bus_wr(5'h08, 32'h0BBB);
        pulse_tmr(0);
        chk("R11 no dma_req without DMA mode", 32'(dma_req), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_align();
        t_disabled();
        t_settle();
        t_finish_clr();
        t_trig_sel();
        t_ext();
        t_busy();
        t_dma();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule